// File: doc/BRIEF.md
# Configurable 64-bit Timer with Watchdog

This block is a counter pair that a small register port sets up for one of three mutually exclusive uses. The two halves of one datapath can act as a single 64-bit general-purpose counter, as two 32-bit counters, or as a watchdog. In the two-counter use the halves either run on their own or are chained, with the low half acting as a prescaler for the high half. Each counter compares itself against its period register. On a match it raises an interrupt pulse and then either reloads to zero or stops. A timer output pin shows the low-side events as single-clock pulses or as a toggling clock. The timer input pin can stand in for the internal clock as the count source.

In watchdog use the 64-bit counter runs on every clock. Software must feed it with a two-key sequence written to the watchdog control register. If the count reaches the period first, a reset output is held high for a fixed number of clocks. Once the watchdog is active, the mode can no longer be changed until the block is reset.

The watchdog service sequence is a state machine with four states. WD_OFF: not active. WD_ARMED: counting and waiting for the first key. WD_KEY1: first key seen. WD_BITE: the reset output is driven. Its transitions are as follows:
- arm: WD_OFF to WD_ARMED, taken when watchdog use becomes active.
- key-one: WD_ARMED to WD_KEY1, taken when the first key is written.
- feed: WD_KEY1 to WD_ARMED, taken when the second key is written; the counter restarts.
- abort: WD_KEY1 to WD_ARMED, taken when any other key is written; the counter does not restart.
- expire: WD_ARMED or WD_KEY1 to WD_BITE, taken when the count reaches the period.
- release: WD_BITE to WD_ARMED, taken after the reset pulse has lasted its full length.

Register word addresses are: 0 low count, 1 high count, 2 low period, 3 high period, 4 timer control, 5 global control, 6 watchdog control. Address 7 reads zero.

Top module: `tmr64_wd`

## Requirements
- R1: After reset the global control mode field reads 0 (64-bit use), both count registers read 0, and irq_lo, irq_hi, timer_out and wd_rst are low.
- R2: Global control bits [1:0] select the use: 0 is 64-bit, 1 is two independent 32-bit counters, 2 is two chained 32-bit counters, 3 is watchdog. irq_hi pulses only in uses 1 and 2.
- R3: In 64-bit use the low half carries into the high half when the low half is all ones. A match happens when the full 64-bit count equals {high period, low period}. In continuous operation a period P gives one event every P+1 counts.
- R4: Timer control bits [1:0] (low or 64-bit) and [3:2] (high) set how a counter runs: 0 stopped, 1 one-shot, 2 or 3 continuous. A one-shot counter gives one event and then holds its period value.
- R5: In independent dual use the high half counts every clock, whatever the low half does.
- R6: In chained dual use the high half advances by one only on each low-half event.
- R7: Timer control bit 5 sets the output style. At 0, timer_out gives a one-clock pulse in the same cycle as each irq_lo pulse. At 1, timer_out toggles once per low-side event.
- R8: When timer control bit 4 is 1, the low or 64-bit counter counts rising edges of timer_in after a two-flop synchronizer. A steady timer_in does not advance the count.
- R9: Watchdog use needs mode 3 and watchdog control bit 0 both set; mode 3 alone leaves the counters idle and the mode changeable. Once watchdog use is active, writes to the mode field are ignored until reset.
- R10: Writing key 0xA5C6 and then key 0xDA7E to watchdog control bits [31:16] restarts the watchdog count. Any other order or value does not restart it.
- R11: When the watchdog count reaches the 64-bit period, wd_rst goes high for exactly WD_BITE_CYC clocks and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | HALF_W | Register write data |
| reg_rdata | output | HALF_W | Register read data for reg_addr |
| timer_in | input | 1 | Timer input pin, optional count source |
| timer_out | output | 1 | Timer output pin, pulse or toggle |
| irq_lo | output | 1 | Low-half or 64-bit period event pulse |
| irq_hi | output | 1 | High-half period event pulse (dual use) |
| wd_rst | output | 1 | Watchdog reset output |

## Verification
The bench builds the block with HALF_W=32 and the default keys. It lowers WD_BITE_CYC to 8, so the reset-pulse width check closes in a few cycles. The watchdog period is set to 40, so a missed service, a wrong key sequence and a full expiry all fit in a short run. The 32-bit halves let the bench preload the low count just below all ones, which exercises the 64-bit carry without long waits. The event-count windows are multiples of each period, so the expected counts do not depend on the phase at which counting starts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        MODE_GP64     = 2'd0,
        MODE_DUAL_IND = 2'd1,
        MODE_DUAL_CHN = 2'd2,
        MODE_WD       = 2'd3
    } tmr_mode_e;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_KEY1  = 2'd2,
        WD_BITE  = 2'd3
    } wd_state_e;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
    import tmr_pkg::*;
#(
    parameter int               KEY_W    = 16,
    parameter logic [KEY_W-1:0] KEY1     = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY2     = 16'hDA7E,
    parameter int               BITE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    input  logic             expire,
    output logic             svc,
    output logic             bite
);
    localparam int CW = $clog2(BITE_CYC + 1);

    wd_state_e st_q, st_d;
    logic [CW-1:0] bite_cnt_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_OFF: begin
                if (active) st_d = WD_ARMED;
            end
            WD_ARMED: begin
                if (expire)                        st_d = WD_BITE;
                else if (key_wr && key_val == KEY1) st_d = WD_KEY1;
            end
            WD_KEY1: begin
                if (expire)      st_d = WD_BITE;
                else if (key_wr) st_d = WD_ARMED;
            end
            WD_BITE: begin
                if (bite_cnt_q == '0) st_d = WD_ARMED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= WD_OFF;
            bite_cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != WD_BITE && st_d == WD_BITE) begin
                bite_cnt_q <= CW'(BITE_CYC - 1);
            end else if (st_q == WD_BITE && bite_cnt_q != '0) begin
                bite_cnt_q <= bite_cnt_q - CW'(1);
            end
        end
    end

    always_comb begin
        svc  = 1'b0;
        bite = 1'b0;
        unique case (st_q)
            WD_OFF:   ;
            WD_ARMED: ;
            WD_KEY1:  svc  = key_wr && (key_val == KEY2) && !expire;
            WD_BITE:  bite = 1'b1;
        endcase
    end
endmodule

// File: rtl/tmr64_wd.sv
module tmr64_wd
    import tmr_pkg::*;
#(
    parameter int               HALF_W      = 32,
    parameter int               ADDR_W      = 3,
    parameter int               KEY_W       = 16,
    parameter logic [KEY_W-1:0] KEY1        = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY2        = 16'hDA7E,
    parameter int               WD_BITE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic              timer_in,
    output logic              timer_out,
    output logic              irq_lo,
    output logic              irq_hi,
    output logic              wd_rst
);
    localparam int A_CNT_LO = 0;
    localparam int A_CNT_HI = 1;
    localparam int A_PRD_LO = 2;
    localparam int A_PRD_HI = 3;
    localparam int A_CTRL   = 4;
    localparam int A_GCTRL  = 5;
    localparam int A_WDCTRL = 6;
    localparam int CTRL_W   = 6;
    localparam int KEY_LSB  = HALF_W - KEY_W;

    logic [HALF_W-1:0] cnt [2];
    logic [HALF_W-1:0] prd_q [2];
    logic [CTRL_W-1:0] ctrl_q;
    tmr_mode_e         mode_q;
    logic              wden_q;
    logic [1:0]        run_q;
    logic [1:0]        inc, clr, ld;
    logic              irq_lo_q, irq_hi_q, out_q;

    logic wd_act, wide, dual, chain, ext_rise, tick_src;
    logic m_lo, m_hi, go, go_lo, go_hi;
    logic ev64, ev_lo, ev_hi, lo_event;
    logic wd_svc, wd_bite, key_wr, wr_ctrl;

    // control field decode
    assign wd_act   = (mode_q == MODE_WD) && wden_q;
    assign wide     = wd_act || (mode_q == MODE_GP64);
    assign dual     = (mode_q == MODE_DUAL_IND) || (mode_q == MODE_DUAL_CHN);
    assign chain    = (mode_q == MODE_DUAL_CHN);
    assign tick_src = ctrl_q[4] ? ext_rise : 1'b1;
    assign m_lo     = (cnt[0] == prd_q[0]);
    assign m_hi     = (cnt[1] == prd_q[1]);
    assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    assign key_wr   = reg_wr && (reg_addr == ADDR_W'(A_WDCTRL)) && wd_act;

    tmr_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (timer_in),
        .rise (ext_rise)
    );

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign ld[g] = reg_wr && (reg_addr == ADDR_W'(A_CNT_LO + g));
        tmr_half #(.W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (ld[g]),
            .ld_val(reg_wdata),
            .clr   (clr[g]),
            .inc   (inc[g]),
            .cnt   (cnt[g])
        );
    end

    // counting datapath shared by all uses
    always_comb begin
        inc   = '0;
        clr   = '0;
        go    = 1'b0;
        go_lo = 1'b0;
        go_hi = 1'b0;
        ev64  = 1'b0;
        ev_lo = 1'b0;
        ev_hi = 1'b0;
        if (wide) begin
            go     = wd_act ? 1'b1 : (run_q[0] & tick_src);
            ev64   = go & m_lo & m_hi;
            inc[0] = go & ~(m_lo & m_hi);
            inc[1] = inc[0] & (&cnt[0]);
            clr[0] = (ev64 & (wd_act | ctrl_q[1])) | wd_svc;
            clr[1] = clr[0];
        end else if (dual) begin
            go_lo  = run_q[0] & tick_src;
            ev_lo  = go_lo & m_lo;
            inc[0] = go_lo & ~m_lo;
            clr[0] = ev_lo & ctrl_q[1];
            go_hi  = run_q[1] & (chain ? ev_lo : 1'b1);
            ev_hi  = go_hi & m_hi;
            inc[1] = go_hi & ~m_hi;
            clr[1] = ev_hi & ctrl_q[3];
        end
    end

    assign lo_event = (ev64 & ~wd_act) | ev_lo;

    tmr_wdog #(
        .KEY_W   (KEY_W),
        .KEY1    (KEY1),
        .KEY2    (KEY2),
        .BITE_CYC(WD_BITE_CYC)
    ) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (wd_act),
        .key_wr (key_wr),
        .key_val(reg_wdata[HALF_W-1:KEY_LSB]),
        .expire (ev64 & wd_act),
        .svc    (wd_svc),
        .bite   (wd_bite)
    );

    // configuration registers and run state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prd_q[0] <= '0;
            prd_q[1] <= '0;
            ctrl_q   <= '0;
            mode_q   <= MODE_GP64;
            wden_q   <= 1'b0;
            run_q    <= '0;
        end else begin
            if (reg_wr && reg_addr == ADDR_W'(A_PRD_LO)) prd_q[0] <= reg_wdata;
            if (reg_wr && reg_addr == ADDR_W'(A_PRD_HI)) prd_q[1] <= reg_wdata;
            if (reg_wr && reg_addr == ADDR_W'(A_GCTRL) && !wd_act)
                mode_q <= tmr_mode_e'(reg_wdata[1:0]);
            if (reg_wr && reg_addr == ADDR_W'(A_WDCTRL) && !wd_act)
                wden_q <= reg_wdata[0];
            if (wr_ctrl) begin
                ctrl_q   <= reg_wdata[CTRL_W-1:0];
                run_q[0] <= |reg_wdata[1:0];
                run_q[1] <= |reg_wdata[3:2];
            end else begin
                if (lo_event && !ctrl_q[1]) run_q[0] <= 1'b0;
                if (ev_hi && !ctrl_q[3])    run_q[1] <= 1'b0;
            end
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_lo_q <= 1'b0;
            irq_hi_q <= 1'b0;
            out_q    <= 1'b0;
        end else begin
            irq_lo_q <= lo_event;
            irq_hi_q <= ev_hi;
            out_q    <= ctrl_q[5] ? (out_q ^ lo_event) : lo_event;
        end
    end

    assign irq_lo    = irq_lo_q;
    assign irq_hi    = irq_hi_q;
    assign timer_out = out_q;
    assign wd_rst    = wd_bite;

    always_comb begin
        case (reg_addr)
            ADDR_W'(A_CNT_LO): reg_rdata = cnt[0];
            ADDR_W'(A_CNT_HI): reg_rdata = cnt[1];
            ADDR_W'(A_PRD_LO): reg_rdata = prd_q[0];
            ADDR_W'(A_PRD_HI): reg_rdata = prd_q[1];
            ADDR_W'(A_CTRL):   reg_rdata = HALF_W'(ctrl_q);
            ADDR_W'(A_GCTRL):  reg_rdata = {{(HALF_W-2){1'b0}}, mode_q};
            ADDR_W'(A_WDCTRL): reg_rdata = HALF_W'(wden_q);
            default:           reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr64_wd_chk.sv
module tmr64_wd_chk
    import tmr_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      wd_act,
    input tmr_mode_e mode_q,
    input logic      out_clk,
    input logic      irq_lo,
    input logic      irq_hi,
    input logic      timer_out,
    input logic      wd_rst
);
    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (mode_q == MODE_GP64 && !irq_lo && !irq_hi && !timer_out && !wd_rst); // R1
        end
    end

    AST_HI_ONLY_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_q == MODE_DUAL_IND || mode_q == MODE_DUAL_CHN) |=> !irq_hi); // R2

    AST_PULSE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !out_clk |=> (timer_out == irq_lo)); // R7

    AST_WD_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wd_act |=> (wd_act && mode_q == MODE_WD)); // R9

    AST_BITE_NEEDS_WD: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst |-> wd_act); // R11
endmodule

bind tmr64_wd tmr64_wd_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_act   (wd_act),
    .mode_q   (mode_q),
    .out_clk  (ctrl_q[5]),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi),
    .timer_out(timer_out),
    .wd_rst   (wd_rst)
);

// File: tb/tmr64_wd_tb_top.sv
module tmr64_wd_tb_top;
    localparam int HW    = 32;
    localparam int BITE  = 8;
    localparam logic [15:0] K1 = 16'hA5C6;
    localparam logic [15:0] K2 = 16'hDA7E;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [2:0]    reg_addr;
    logic [HW-1:0] reg_wdata;
    logic [HW-1:0] reg_rdata;
    logic          timer_in = 1'b0;
    logic          timer_out, irq_lo, irq_hi, wd_rst;

    int total = 0;
    int bad = 0;
    int n_lo, n_hi, n_out, n_tog;
    int wd_hi_cnt = 0;
    int tcnt = 0;
    logic tin_en = 1'b0;
    logic [HW-1:0] rd_v;

    always #4 clk = ~clk;

    tmr64_wd #(.HALF_W(HW), .WD_BITE_CYC(BITE)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_in(timer_in),
        .timer_out(timer_out), .irq_lo(irq_lo), .irq_hi(irq_hi), .wd_rst(wd_rst)
    );

    always @(negedge clk) begin
        if (wd_rst) wd_hi_cnt++;
        if (tin_en) begin
            tcnt++;
            if (tcnt == 4) begin
                timer_in <= ~timer_in;
                tcnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [HW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [HW-1:0] d);
        @(negedge clk);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic window(input int n);
        logic prev;
        n_lo = 0; n_hi = 0; n_out = 0; n_tog = 0;
        prev = timer_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_lo) n_lo++;
            if (irq_hi) n_hi++;
            if (timer_out) n_out++;
            if (timer_out != prev) n_tog++;
            prev = timer_out;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic prep(input int mode, input logic [HW-1:0] plo, input logic [HW-1:0] phi);
        wr(4, 0);
        wr(5, HW'(mode));
        wr(0, 0);
        wr(1, 0);
        wr(2, plo);
        wr(3, phi);
    endtask

    task automatic t_reset();
        rd(5, rd_v); chk(rd_v[1:0] == 2'd0, "R1 mode", rd_v[1:0], 0);
        rd(0, rd_v); chk(rd_v == 0, "R1 cnt_lo", rd_v, 0);
        rd(1, rd_v); chk(rd_v == 0, "R1 cnt_hi", rd_v, 0);
        chk({irq_lo, irq_hi, timer_out, wd_rst} == 4'b0, "R1 outputs",
            {irq_lo, irq_hi, timer_out, wd_rst}, 0);
    endtask

    task automatic t_gp64();
        prep(0, 4, 0);
        wr(4, 6'h02);
        repeat (7) @(negedge clk);
        window(50);
        chk(n_lo == 10, "R3 gp64 events", n_lo, 10);
        chk(n_out == 10, "R7 pulse count", n_out, 10);
        chk(n_hi == 0, "R2 no irq_hi in 64-bit", n_hi, 0);
    endtask

    task automatic t_carry();
        prep(0, 5, 1);
        wr(0, 32'hFFFF_FFFD);
        wr(4, 6'h02);
        repeat (5) @(negedge clk);
        rd(1, rd_v);
        chk(rd_v == 1, "R3 carry into high", rd_v, 1);
    endtask

    task automatic t_oneshot();
        prep(0, 3, 0);
        wr(4, 6'h01);
        window(30);
        chk(n_lo == 1, "R4 one-shot events", n_lo, 1);
        rd(0, rd_v);
        chk(rd_v == 3, "R4 one-shot hold", rd_v, 3);
    endtask

    task automatic t_unchained();
        prep(1, 2, 6);
        wr(4, 6'h0A);
        repeat (5) @(negedge clk);
        window(42);
        chk(n_lo == 14, "R5 unchained lo", n_lo, 14);
        chk(n_hi == 6, "R5 unchained hi", n_hi, 6);
    endtask

    task automatic t_chained();
        prep(2, 2, 3);
        wr(4, 6'h0A);
        repeat (5) @(negedge clk);
        window(48);
        chk(n_lo == 16, "R6 chained lo", n_lo, 16);
        chk(n_hi == 4, "R6 chained hi", n_hi, 4);
    endtask

    task automatic t_clkout();
        prep(0, 4, 0);
        wr(4, 6'h22);
        repeat (7) @(negedge clk);
        window(50);
        chk(n_tog == 10, "R7 toggle count", n_tog, 10);
    endtask

    task automatic t_ext();
        prep(0, 1, 0);
        tin_en = 1'b1;
        wr(4, 6'h12);
        repeat (20) @(negedge clk);
        window(64);
        chk(n_lo == 4, "R8 ext edges", n_lo, 4);
        tin_en = 1'b0;
        repeat (10) @(negedge clk);
        window(64);
        chk(n_lo == 0, "R8 steady input", n_lo, 0);
    endtask

    task automatic t_wdog();
        int base;
        bit seen;
        prep(3, 40, 0);
        base = wd_hi_cnt;
        repeat (100) @(negedge clk);
        chk(wd_hi_cnt == base, "R9 no bite without enable", wd_hi_cnt - base, 0);
        wr(5, 0);
        rd(5, rd_v);
        chk(rd_v[1:0] == 2'd0, "R9 mode free before enable", rd_v[1:0], 0);
        wr(5, 3);
        wr(6, 1);
        wr(5, 0);
        rd(5, rd_v);
        chk(rd_v[1:0] == 2'd3, "R9 mode locked", rd_v[1:0], 3);
        base = wd_hi_cnt;
        for (int i = 0; i < 10; i++) begin
            wr(6, {K1, 16'h0001});
            wr(6, {K2, 16'h0001});
            repeat (16) @(negedge clk);
        end
        chk(wd_hi_cnt == base, "R10 serviced no bite", wd_hi_cnt - base, 0);
        base = wd_hi_cnt;
        wr(6, {K2, 16'h0001});
        wr(6, {K1, 16'h0001});
        wr(6, {16'h1234, 16'h0001});
        wr(6, {K2, 16'h0001});
        seen = 1'b0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (wd_rst) seen = 1'b1;
        end
        chk(seen, "R10 bad sequence bites", seen, 1);
        for (int i = 0; i < 40 && wd_rst; i++) @(negedge clk);
        chk(wd_hi_cnt - base == BITE, "R11 bite width", wd_hi_cnt - base, BITE);
        do_reset();
        rd(5, rd_v);
        chk(rd_v[1:0] == 2'd0, "R1 reset clears lock", rd_v[1:0], 0);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_gp64();
        t_carry();
        t_oneshot();
        t_unchained();
        t_chained();
        t_clkout();
        t_ext();
        t_wdog();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule